// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block generates a pulse-width modulated output. Duty values do not reach the output directly. Software writes them into a short queue, and the modulator takes the oldest queued value each time its period counter wraps. While the queue is empty, the last duty taken stays in force for as long as needed. A free-running divider clocks the period counter, so the counter advances once every `div+1` input clocks.

The block has a small register port with a one-cycle write strobe and a combinational read. Through it, software can enable the modulator, set the divider and the period, push duty samples, and watch the queue fill level together with a sticky overflow flag. When software turns the modulator off, the queue is emptied and the counter returns to zero. When software turns it back on, the first period runs with the first queued sample, or with 0 if nothing was queued.

Top module: `pwm_dutyq`

## Requirements
- R1: After reset, `pwm_out` is low, and the control, status, sample and period registers all read 0.
- R2: The register select `reg_addr` picks one of four registers. Address 0 is control: bit 0 enables the modulator and bits [12:1] hold the divider `div`. Address 1 is status: bits [2:0] give the queue fill level, where 0 means empty, and bit 3 is the overflow flag. Address 2 is the duty sample register. Address 3 is the period register.
- R3: A write to the sample register adds the value to the queue and raises the fill level by one. The duty of the period already in progress does not change.
- R4: Each counter state lasts `div+1` clocks. A period lasts P counter states, counting 0 to P-1. `pwm_out` is high while the counter is below the active duty.
- R5: Queued duties are applied in the order they were written. Exactly one is applied at each counter wrap, starting with the first clock after the wrap.
- R6: While the queue is empty, later periods keep repeating the last applied duty.
- R7: A read of the sample register returns the oldest queued duty when the queue is not empty. Otherwise it returns the active duty.
- R8: A duty of 0 keeps the output low for the whole period. A duty equal to or above P keeps it high for the whole period.
- R9: Writing 0xFFFF to the period register stores 0xFFFE. Any other value is stored as written.
- R10: A sample write that arrives while the queue holds 4 entries, with no pop in the same cycle, is discarded and sets the overflow flag. The flag stays set until a status write with bit 3 set clears it.
- R11: Clearing the enable bit empties the queue, resets the counter and divider, and drives `pwm_out` low within two clocks. The first period after the enable is set again uses the first queued duty, or 0 if the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench times each duty handover against the counter wrap. A design that pops one clock early or late shows it as a wrong high count within one period. A design that applies a write at once is caught by a low sample taken mid-period, where a high one would be wrong. The bench overfills the queue and then plays it back: if the extra write were kept, the last period would use the wrong duty and the overflow flag would stay clear. A period of one state, a duty of zero and a duty above the period check the compare edges. A disable with samples still queued, followed by a re-enable, must produce an all-low first period; a design that keeps stale entries or the old duty would output high.

// File: rtl/pwm_dutyq_pkg.sv
package pwm_dutyq_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_STAT   = 2'd1,
      SEL_SAMPLE = 2'd2,
      SEL_PERIOD = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/pwm_dutyq_fifo.sv
module pwm_dutyq_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     head,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign head    = mem[rd_ptr];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         if (push_ok && !pop_ok)      level <= level + 1'b1;
         else if (pop_ok && !push_ok) level <= level - 1'b1;
      end
   end

   assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> level == $past(level));

   assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !flush) |=> level == $past(level) + 1'b1);

   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> level == '0);
endmodule

// File: rtl/pwm_dutyq_presc.sv
module pwm_dutyq_presc #(
   parameter int PW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] div,
   output logic          tick
);
   logic [PW-1:0] acc;

   assign tick = run && (acc >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (!run)  acc <= '0;
      else if (tick)  acc <= '0;
      else            acc <= acc + 1'b1;
   end

   assert_tick_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> acc == '0);
endmodule

// File: rtl/pwm_dutyq_cnt.sv
module pwm_dutyq_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   logic [W:0] nxt;

   assign nxt  = {1'b0, cnt} + 1'b1;
   assign wrap = tick && (nxt >= {1'b0, period});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (tick)  cnt <= wrap ? '0 : nxt[W-1:0];
   end

   assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt == '0);
endmodule

// File: rtl/pwm_dutyq.sv
module pwm_dutyq
   import pwm_dutyq_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 4,
   parameter int PRESC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              pwm_out
);
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam logic [DATA_W-1:0] PER_MAX = {{(DATA_W-1){1'b1}}, 1'b0};

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pwm_dutyq: DEPTH must be at least 2");
      end
      if (PRESC_W + 1 > DATA_W) begin : g_bad_presc
         $error("pwm_dutyq: divider field does not fit the control register");
      end
      if (LVL_W + 1 > DATA_W) begin : g_bad_stat
         $error("pwm_dutyq: status fields do not fit the data width");
      end
   endgenerate

   logic               en_q, run_q, ovf_q;
   logic [PRESC_W-1:0] div_q;
   logic [DATA_W-1:0]  period_q, active_q;
   logic               wr_ctrl, wr_stat, wr_smp, wr_per;
   logic               start, stop, live, tick, wrap, pop_req, drop;
   logic [DATA_W-1:0]  cnt, head;
   logic [LVL_W-1:0]   level;
   logic               full, empty;
   reg_sel_e           sel;

   assign sel     = reg_sel_e'(reg_addr);
   assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
   assign wr_stat = reg_wr && (sel == SEL_STAT);
   assign wr_smp  = reg_wr && (sel == SEL_SAMPLE);
   assign wr_per  = reg_wr && (sel == SEL_PERIOD);

   assign start   = en_q && !run_q;
   assign stop    = !en_q && run_q;
   assign live    = en_q && run_q;
   assign pop_req = start || wrap;
   assign drop    = wr_smp && full && !pop_req;

   pwm_dutyq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (stop),
      .push  (wr_smp),
      .pop   (pop_req),
      .din   (reg_wdata),
      .head  (head),
      .level (level),
      .full  (full),
      .empty (empty)
   );

   pwm_dutyq_presc #(.PW(PRESC_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (live),
      .div   (div_q),
      .tick  (tick)
   );

   pwm_dutyq_cnt #(.W(DATA_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (live),
      .tick   (tick),
      .period (period_q),
      .cnt    (cnt),
      .wrap   (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         div_q    <= '0;
         period_q <= '0;
         ovf_q    <= 1'b0;
         run_q    <= 1'b0;
         active_q <= '0;
      end else begin
         run_q <= en_q;
         if (wr_ctrl) begin
            en_q  <= reg_wdata[0];
            div_q <= reg_wdata[PRESC_W:1];
         end
         if (wr_per) period_q <= (reg_wdata == '1) ? PER_MAX : reg_wdata;
         if (drop)                        ovf_q <= 1'b1;
         else if (wr_stat && reg_wdata[LVL_W]) ovf_q <= 1'b0;
         if (start)              active_q <= empty ? '0 : head;
         else if (wrap && !empty) active_q <= head;
      end
   end

   assign pwm_out = run_q && (cnt < active_q);

   always_comb begin
      unique case (sel)
         SEL_CTRL:   reg_rdata = DATA_W'({div_q, en_q});
         SEL_STAT:   reg_rdata = DATA_W'({ovf_q, level});
         SEL_SAMPLE: reg_rdata = empty ? active_q : head;
         SEL_PERIOD: reg_rdata = period_q;
         default:    reg_rdata = '0;
      endcase
   end

   assert_hold_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !wrap) |=> $stable(active_q));

   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !wr_stat) |=> ovf_q);

   assert_off_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !pwm_out);
endmodule

// File: tb/pwm_dutyq_tb.sv
module pwm_dutyq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        pwm_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm_dutyq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pwm_out   (pwm_out)
   );

   // divider, period, duty, expected high clocks over one period
   localparam int NV = 8;
   localparam int VEC [NV][4] = '{
      '{0, 10,  3,  3},
      '{0, 10,  0,  0},
      '{0, 10, 10, 10},
      '{0, 10, 15, 10},
      '{1,  8,  5, 10},
      '{3,  5,  2,  8},
      '{2,  6,  6, 18},
      '{0,  1,  1,  1}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      reg_addr = a;
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic count_high(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out) hi++;
      end
   endtask

   initial begin
      int v, hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 out", int'(pwm_out), 0);
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd1, v); chk("R1 status", v, 0);
      rd(2'd2, v); chk("R1 sample", v, 0);
      rd(2'd3, v); chk("R1 period", v, 0);

      // R9 period clamp
      wr(2'd3, 16'hFFFF);
      rd(2'd3, v); chk("R9 clamp", v, 16'hFFFE);
      wr(2'd3, 16'h1234);
      rd(2'd3, v); chk("R9 plain", v, 16'h1234);

      // R4 R8 table of divider/period/duty cases
      for (int k = 0; k < NV; k++) begin
         wr(2'd0, 16'd0);
         wr(2'd3, 16'(VEC[k][1]));
         wr(2'd2, 16'(VEC[k][2]));
         wr(2'd0, 16'((VEC[k][0] << 1) | 1));
         count_high(VEC[k][1] * (VEC[k][0] + 1), hi);
         chk($sformatf("R4 R8 vector %0d highs", k), hi, VEC[k][3]);
         rd(2'd1, v); chk($sformatf("R2 vector %0d level", k), v & 7, 0);
      end

      // R3 R5 R6 R7 ordering and handover at the wrap
      wr(2'd0, 16'd0);
      wr(2'd3, 16'd10);
      wr(2'd2, 16'd2);
      wr(2'd0, 16'd1);
      wr(2'd2, 16'd5);
      wr(2'd2, 16'd7);
      rd(2'd1, v); chk("R3 level after two writes", v, 2);
      chk("R3 duty unchanged mid-period", int'(pwm_out), 0);
      rd(2'd2, v); chk("R7 head read", v, 5);
      repeat (6) @(negedge clk);
      count_high(10, hi); chk("R5 second period", hi, 5);
      rd(2'd2, v); chk("R7 next queued", v, 7);
      count_high(10, hi); chk("R5 third period", hi, 7);
      rd(2'd1, v); chk("R6 level empty", v, 0);
      rd(2'd2, v); chk("R7 active when empty", v, 7);
      count_high(10, hi); chk("R6 held duty", hi, 7);

      // R10 overflow
      wr(2'd0, 16'd0);
      wr(2'd3, 16'd4);
      for (int j = 1; j <= 5; j++) wr(2'd2, 16'(j));
      rd(2'd1, v); chk("R10 full with overflow", v, 12);
      rd(2'd2, v); chk("R10 head kept", v, 1);
      wr(2'd1, 16'd0);
      rd(2'd1, v); chk("R10 flag sticky", v, 12);
      wr(2'd1, 16'd8);
      rd(2'd1, v); chk("R10 flag cleared", v, 4);
      wr(2'd0, 16'd1);
      for (int j = 1; j <= 5; j++) begin
         count_high(4, hi);
         chk($sformatf("R10 R5 playback period %0d", j), hi, (j > 4) ? 4 : j);
      end

      // R11 disable flushes, re-enable with empty queue gives duty 0
      wr(2'd2, 16'd3);
      wr(2'd2, 16'd3);
      wr(2'd0, 16'd0);
      @(negedge clk);
      chk("R11 out low", int'(pwm_out), 0);
      rd(2'd1, v); chk("R11 flushed", v, 0);
      wr(2'd0, 16'd1);
      count_high(4, hi); chk("R11 empty restart duty 0", hi, 0);
      wr(2'd0, 16'd0);
      wr(2'd2, 16'd3);
      wr(2'd0, 16'd1);
      count_high(4, hi); chk("R11 restart first queued", hi, 3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule